// File: doc/BRIEF.md
# MPU Region Match and Permission Check

This block decides whether a single memory access may go ahead under a region-based memory protection unit. It receives the access address, a privilege flag, a write flag and an instruction-fetch flag, together with the full configuration of every region laid out in parallel. Each region has a base, a size exponent, an enable bit, a 3-bit access-rights code, an execute-never bit and a 6-bit memory attribute field.

Every region compares the address against its base above a size-dependent bit position. A priority selector picks the highest-numbered enabled region that matches. That region's rights code and execute-never bit then allow the access or flag a fault. The verdict, the winning region index and its attributes are registered and appear one clock after the inputs are applied.

A global enable input switches the whole check off. While it is low every access passes. The block is meant to sit in the load/store and fetch paths, and is fed by a register bank that is kept outside it.

Top module: `mpu_chk_top`

## Requirements
- R1: Size code N (5 bits) spans 2^(N+1) bytes. Only address bits N+1 and above are compared with the base, so base bits below N+1 are ignored. Code 31 matches every address, and codes 0 to 3 never match.
- R2: A region whose enable bit is 0 never matches, whatever its base and size.
- R3: When several enabled regions match, hit_o is 1 and region_idx_o names the highest-numbered one.
- R4: An access matched by no region gives fault_type_o = 2'b01 (background), hit_o = 0, region_idx_o = 0 and attr_o = 0.
- R5: For a data access, rights code 000 gives no access; 001 gives privileged read/write only; 010 gives privileged read/write and user read; 011 gives read/write to both; 101 gives privileged read only; 110 gives read only to both. A denied access gives fault_type_o = 2'b10 (permission).
- R6: Rights codes 100 and 111 deny every access with fault_type_o = 2'b10.
- R7: For a fetch (fetch_i = 1), write_i is ignored. Without read rights the fetch gives 2'b10. With read rights and execute-never set it gives 2'b11. Otherwise it passes.
- R8: While mpu_en_i is 0, fault_o = 0, fault_type_o = 2'b00, hit_o = 0, region_idx_o = 0 and attr_o = 0.
- R9: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. Reset clears every output to 0.
- R10: attr_o carries the matched region's 6-bit attribute field {tex[2:0], s, c, b} unchanged. fault_o is 1 exactly when fault_type_o is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mpu_en_i | input | 1 | Global protection enable |
| addr_i | input | ADDR_W | Access address |
| priv_i | input | 1 | 1 = privileged access |
| write_i | input | 1 | 1 = data write |
| fetch_i | input | 1 | 1 = instruction fetch |
| region_base_i | input | NUM_REG*ADDR_W | Region bases, region i at slice i |
| region_size_i | input | NUM_REG*5 | Region size codes |
| region_en_i | input | NUM_REG | Region enable bits |
| region_ap_i | input | NUM_REG*3 | Region access-rights codes |
| region_xn_i | input | NUM_REG | Region execute-never bits |
| region_attr_i | input | NUM_REG*6 | Region attributes {tex,s,c,b} |
| fault_o | output | 1 | Access faulted |
| fault_type_o | output | 2 | 00 none, 01 background, 10 permission, 11 execute-never |
| hit_o | output | 1 | An enabled region matched |
| region_idx_o | output | IDX_W | Winning region index |
| attr_o | output | 6 | Winning region attributes |

## Verification
The assertions check on every cycle that a background fault never comes with a hit and has zero attributes, and that permission and execute-never faults always come with a hit. They also check that a reported hit names a region that was enabled, that a disabled unit reports nothing, and that the fault flag agrees with the fault type. Only the bench scenarios can show that the address mask follows the size exponent, that a higher index wins an overlap, and that each rights code grants exactly what its row says for each privilege and direction. The same holds for the split between permission and execute-never faults on fetches.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;
  localparam int SIZE_W        = 5;
  localparam int AP_W          = 3;
  localparam int ATTR_W        = 6;
  localparam int MIN_SIZE_CODE = 4;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_BG   = 2'b01,
    FLT_PERM = 2'b10,
    FLT_XN   = 2'b11
  } fault_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } rights_t;

  // rights granted by an AP code at one privilege level; reserved codes grant nothing
  function automatic rights_t ap_rights(input logic [AP_W-1:0] ap, input logic priv);
    rights_t r;
    r = '0;
    unique case (ap)
      3'b001: r = priv ? 2'b11 : 2'b00;
      3'b010: r = priv ? 2'b11 : 2'b10;
      3'b011: r = 2'b11;
      3'b101: r = priv ? 2'b10 : 2'b00;
      3'b110: r = 2'b10;
      default: r = 2'b00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              en_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] keep;
  logic              size_ok;

  // compare only bits above the size exponent
  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      keep[b] = (b > int'(size_i));
    end
  end

  assign size_ok = (int'(size_i) >= MIN_SIZE_CODE);
  assign hit_o   = en_i && size_ok && (((addr_i ^ base_i) & keep) == '0);
endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel #(
  parameter int NUM_REG = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_REG-1:0] hit_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  // later (higher) index overrides
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_REG; i++) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check
  import mpu_chk_pkg::*;
(
  input  logic            hit_i,
  input  logic [AP_W-1:0] ap_i,
  input  logic            xn_i,
  input  logic            priv_i,
  input  logic            write_i,
  input  logic            fetch_i,
  output logic            allow_o,
  output fault_e          type_o
);
  rights_t rt;
  logic    data_ok;

  assign rt      = ap_rights(ap_i, priv_i);
  assign data_ok = write_i ? rt.wr : rt.rd;

  always_comb begin
    if (!hit_i)                type_o = FLT_BG;
    else if (fetch_i) begin
      if (!rt.rd)              type_o = FLT_PERM;
      else if (xn_i)           type_o = FLT_XN;
      else                     type_o = FLT_NONE;
    end
    else if (!data_ok)         type_o = FLT_PERM;
    else                       type_o = FLT_NONE;
  end

  assign allow_o = hit_i && (fetch_i ? (rt.rd && !xn_i) : data_ok);
endmodule

// File: rtl/mpu_chk_top.sv
module mpu_chk_top
  import mpu_chk_pkg::*;
#(
  parameter int NUM_REG = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mpu_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      priv_i,
  input  logic                      write_i,
  input  logic                      fetch_i,
  input  logic [NUM_REG*ADDR_W-1:0] region_base_i,
  input  logic [NUM_REG*SIZE_W-1:0] region_size_i,
  input  logic [NUM_REG-1:0]        region_en_i,
  input  logic [NUM_REG*AP_W-1:0]   region_ap_i,
  input  logic [NUM_REG-1:0]        region_xn_i,
  input  logic [NUM_REG*ATTR_W-1:0] region_attr_i,
  output logic                      fault_o,
  output logic [1:0]                fault_type_o,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          region_idx_o,
  output logic [ATTR_W-1:0]         attr_o
);
  logic [NUM_REG-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic [AP_W-1:0]    sel_ap;
  logic               sel_xn;
  logic [ATTR_W-1:0]  sel_attr;
  logic               allow;
  fault_e             ftype;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    mpu_region_match #(.ADDR_W(ADDR_W)) u_match (
      .addr_i (addr_i),
      .base_i (region_base_i[g*ADDR_W +: ADDR_W]),
      .size_i (region_size_i[g*SIZE_W +: SIZE_W]),
      .en_i   (region_en_i[g]),
      .hit_o  (hit_vec[g])
    );
  end

  mpu_prio_sel #(.NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_prio (
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (sel_idx)
  );

  assign sel_ap   = region_ap_i[sel_idx*AP_W +: AP_W];
  assign sel_xn   = region_xn_i[sel_idx];
  assign sel_attr = any_hit ? region_attr_i[sel_idx*ATTR_W +: ATTR_W] : '0;

  mpu_perm_check u_perm (
    .hit_i   (any_hit),
    .ap_i    (sel_ap),
    .xn_i    (sel_xn),
    .priv_i  (priv_i),
    .write_i (write_i),
    .fetch_i (fetch_i),
    .allow_o (allow),
    .type_o  (ftype)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o      <= 1'b0;
      fault_type_o <= 2'b00;
      hit_o        <= 1'b0;
      region_idx_o <= '0;
      attr_o       <= '0;
    end else if (!mpu_en_i) begin
      fault_o      <= 1'b0;
      fault_type_o <= 2'b00;
      hit_o        <= 1'b0;
      region_idx_o <= '0;
      attr_o       <= '0;
    end else begin
      fault_o      <= !allow;
      fault_type_o <= ftype;
      hit_o        <= any_hit;
      region_idx_o <= any_hit ? sel_idx : '0;
      attr_o       <= sel_attr;
    end
  end

  // checker state
  logic               past_ok;
  logic               mpu_en_q;
  logic [NUM_REG-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok  <= 1'b0;
      mpu_en_q <= 1'b0;
      en_q     <= '0;
    end else begin
      past_ok  <= 1'b1;
      mpu_en_q <= mpu_en_i;
      en_q     <= region_en_i;
    end
  end

  p_bg_no_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_type_o == FLT_BG) |-> (!hit_o && attr_o == '0 && region_idx_o == '0));

  p_perm_has_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_type_o == FLT_PERM || fault_type_o == FLT_XN) |-> hit_o);

  p_hit_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && hit_o) |-> en_q[region_idx_o]);

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !mpu_en_q) |-> (!fault_o && fault_type_o == FLT_NONE && !hit_o));

  p_flag_type_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == (fault_type_o != FLT_NONE));
endmodule

// File: tb/tb_mpu_chk_top.sv
module tb_mpu_chk_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          mpu_en, priv, wr, fetch;
  logic [AW-1:0] addr;
  logic [31:0]   base [NR];
  logic [4:0]    size [NR];
  logic          en   [NR];
  logic [2:0]    ap   [NR];
  logic          xn   [NR];
  logic [5:0]    attr [NR];

  logic [NR*AW-1:0] base_v;
  logic [NR*5-1:0]  size_v;
  logic [NR-1:0]    en_v, xn_v;
  logic [NR*3-1:0]  ap_v;
  logic [NR*6-1:0]  attr_v;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      base_v[i*AW +: AW] = base[i];
      size_v[i*5 +: 5]   = size[i];
      en_v[i]            = en[i];
      xn_v[i]            = xn[i];
      ap_v[i*3 +: 3]     = ap[i];
      attr_v[i*6 +: 6]   = attr[i];
    end
  end

  logic       fault, hit;
  logic [1:0] ftype;
  logic [3:0] idx;
  logic [5:0] attr_o;

  mpu_chk_top #(.NUM_REG(NR), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mpu_en_i(mpu_en), .addr_i(addr),
    .priv_i(priv), .write_i(wr), .fetch_i(fetch),
    .region_base_i(base_v), .region_size_i(size_v), .region_en_i(en_v),
    .region_ap_i(ap_v), .region_xn_i(xn_v), .region_attr_i(attr_v),
    .fault_o(fault), .fault_type_o(ftype), .hit_o(hit),
    .region_idx_o(idx), .attr_o(attr_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_regions();
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      base[i] = '0; size[i] = '0; en[i] = 1'b0;
      ap[i] = '0; xn[i] = 1'b0; attr[i] = '0;
    end
  endtask

  task automatic set_region(input int i, input logic [31:0] b, input logic [4:0] s,
                            input logic [2:0] a, input logic x, input logic [5:0] at);
    @(negedge clk);
    base[i] = b; size[i] = s; en[i] = 1'b1; ap[i] = a; xn[i] = x; attr[i] = at;
  endtask

  // drive at negedge, result registered at next posedge, sample after it
  task automatic access(input logic [31:0] a, input logic p, input logic w, input logic f);
    @(negedge clk);
    addr = a; priv = p; wr = w; fetch = f;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic [1:0] t, input logic h,
                            input logic [3:0] i, input logic [5:0] at);
    chk(req, "fault_type", 32'(ftype), 32'(t));
    chk(req, "fault_flag", 32'(fault), 32'(t != 2'b00));
    chk(req, "hit", 32'(hit), 32'(h));
    chk(req, "idx", 32'(idx), 32'(i));
    chk(req, "attr", 32'(attr_o), 32'(at));
  endtask

  task automatic t_reset();
    chk("R9", "reset fault_type", 32'(ftype), 0);
    chk("R9", "reset hit", 32'(hit), 0);
    chk("R9", "reset attr", 32'(attr_o), 0);
    chk("R9", "reset idx", 32'(idx), 0);
  endtask

  task automatic t_size();
    clear_regions();
    // code 9 -> 1 KB; low base bits set but ignored
    set_region(0, 32'h0000_10FF, 5'd9, 3'b011, 1'b0, 6'h15);
    access(32'h0000_1000, 1'b1, 1'b0, 1'b0); expect_out("R1", 2'b00, 1'b1, 4'd0, 6'h15);
    access(32'h0000_13FC, 1'b0, 1'b1, 1'b0); expect_out("R1", 2'b00, 1'b1, 4'd0, 6'h15);
    access(32'h0000_1400, 1'b1, 1'b0, 1'b0); expect_out("R1", 2'b01, 1'b0, 4'd0, 6'h00);
    access(32'h0000_0FFC, 1'b1, 1'b0, 1'b0); expect_out("R1", 2'b01, 1'b0, 4'd0, 6'h00);
    // code 4 -> 32 bytes
    set_region(1, 32'h0000_8000, 5'd4, 3'b011, 1'b0, 6'h21);
    access(32'h0000_801F, 1'b1, 1'b0, 1'b0); expect_out("R1", 2'b00, 1'b1, 4'd1, 6'h21);
    access(32'h0000_8020, 1'b1, 1'b0, 1'b0); expect_out("R1", 2'b01, 1'b0, 4'd0, 6'h00);
    // invalid code 3 never matches
    set_region(2, 32'h0000_9000, 5'd3, 3'b011, 1'b0, 6'h01);
    access(32'h0000_9000, 1'b1, 1'b0, 1'b0); expect_out("R1", 2'b01, 1'b0, 4'd0, 6'h00);
    // code 31 covers everything
    set_region(3, 32'hDEAD_BEEF, 5'd31, 3'b011, 1'b0, 6'h3F);
    access(32'hFFFF_FFF0, 1'b0, 1'b0, 1'b0); expect_out("R1", 2'b00, 1'b1, 4'd3, 6'h3F);
  endtask

  task automatic t_enable();
    clear_regions();
    set_region(4, 32'h2000_0000, 5'd19, 3'b011, 1'b0, 6'h0A);
    access(32'h2000_0100, 1'b1, 1'b0, 1'b0); expect_out("R2", 2'b00, 1'b1, 4'd4, 6'h0A);
    @(negedge clk); en[4] = 1'b0;
    access(32'h2000_0100, 1'b1, 1'b0, 1'b0); expect_out("R2", 2'b01, 1'b0, 4'd0, 6'h00);
    access(32'h3000_0000, 1'b1, 1'b1, 1'b0); expect_out("R4", 2'b01, 1'b0, 4'd0, 6'h00);
  endtask

  task automatic t_prio();
    clear_regions();
    set_region(2,  32'h0000_0000, 5'd31, 3'b011, 1'b0, 6'h02);
    set_region(5,  32'h4000_0000, 5'd15, 3'b110, 1'b0, 6'h05);
    set_region(11, 32'h4000_0000, 5'd7,  3'b001, 1'b0, 6'h0B);
    access(32'h4000_0010, 1'b1, 1'b0, 1'b0); expect_out("R3", 2'b00, 1'b1, 4'd11, 6'h0B);
    access(32'h4000_1000, 1'b1, 1'b1, 1'b0); expect_out("R3", 2'b10, 1'b1, 4'd5, 6'h05);
    access(32'h8000_0000, 1'b0, 1'b1, 1'b0); expect_out("R3", 2'b00, 1'b1, 4'd2, 6'h02);
    @(negedge clk); en[11] = 1'b0;
    access(32'h4000_0010, 1'b0, 1'b0, 1'b0); expect_out("R3", 2'b00, 1'b1, 4'd5, 6'h05);
  endtask

  function automatic logic [1:0] exp_rights(input logic [2:0] a, input logic p); // {rd,wr}
    case (a)
      3'b001: return p ? 2'b11 : 2'b00;
      3'b010: return p ? 2'b11 : 2'b10;
      3'b011: return 2'b11;
      3'b101: return p ? 2'b10 : 2'b00;
      3'b110: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic t_ap();
    clear_regions();
    for (int a = 0; a < 8; a++) begin
      set_region(7, 32'h0, 5'd31, 3'(a), 1'b0, 6'h11);
      for (int m = 0; m < 4; m++) begin
        logic p, w, ok;
        logic [1:0] r;
        p = m[1]; w = m[0];
        r = exp_rights(3'(a), p);
        ok = w ? r[0] : r[1];
        access(32'h1234_5678, p, w, 1'b0);
        chk((a == 4 || a == 7) ? "R6" : "R5", $sformatf("ap=%0d priv=%0d wr=%0d", a, p, w),
            32'(ftype), ok ? 32'd0 : 32'd2);
      end
    end
  endtask

  task automatic t_fetch();
    clear_regions();
    set_region(0, 32'h0, 5'd31, 3'b110, 1'b0, 6'h03);
    access(32'h100, 1'b0, 1'b0, 1'b1); expect_out("R7", 2'b00, 1'b1, 4'd0, 6'h03);
    access(32'h100, 1'b0, 1'b1, 1'b1); expect_out("R7", 2'b00, 1'b1, 4'd0, 6'h03);
    @(negedge clk); xn[0] = 1'b1;
    access(32'h100, 1'b1, 1'b0, 1'b1); expect_out("R7", 2'b11, 1'b1, 4'd0, 6'h03);
    @(negedge clk); ap[0] = 3'b001;
    access(32'h100, 1'b0, 1'b0, 1'b1); expect_out("R7", 2'b10, 1'b1, 4'd0, 6'h03);
    access(32'h100, 1'b1, 1'b0, 1'b1); expect_out("R7", 2'b11, 1'b1, 4'd0, 6'h03);
    @(negedge clk); xn[0] = 1'b0;
    access(32'h100, 1'b1, 1'b1, 1'b1); expect_out("R7", 2'b00, 1'b1, 4'd0, 6'h03);
    // execute-never does not affect data reads
    @(negedge clk); xn[0] = 1'b1; ap[0] = 3'b011;
    access(32'h100, 1'b0, 1'b0, 1'b0); expect_out("R7", 2'b00, 1'b1, 4'd0, 6'h03);
  endtask

  task automatic t_off();
    clear_regions();
    set_region(6, 32'h0, 5'd31, 3'b000, 1'b1, 6'h2A);
    @(negedge clk); mpu_en = 1'b0;
    access(32'h55, 1'b0, 1'b1, 1'b0); expect_out("R8", 2'b00, 1'b0, 4'd0, 6'h00);
    access(32'h55, 1'b0, 1'b0, 1'b1); expect_out("R8", 2'b00, 1'b0, 4'd0, 6'h00);
    @(negedge clk); mpu_en = 1'b1;
    access(32'h55, 1'b0, 1'b0, 1'b0); expect_out("R10", 2'b10, 1'b1, 4'd6, 6'h2A);
  endtask

  task automatic t_latency();
    clear_regions();
    set_region(1, 32'h0, 5'd31, 3'b011, 1'b0, 6'h07);
    access(32'h0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); en[1] = 1'b0;
    #1;
    chk("R9", "output held before edge", 32'(hit), 1);
    @(posedge clk); #1;
    chk("R9", "output after edge", 32'(ftype), 1);
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mpu_en = 1'b1; priv = 1'b0; wr = 1'b0; fetch = 1'b0; addr = '0;
    for (int i = 0; i < NR; i++) begin
      base[i] = '0; size[i] = '0; en[i] = 1'b0; ap[i] = '0; xn[i] = 1'b0; attr[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_size();
    t_enable();
    t_prio();
    t_ap();
    t_fetch();
    t_off();
    t_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule